// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out interrupt entry for a 16-bit 65xx-family core with a 24-bit address space (an 8-bit bank plus a 16-bit offset). A start pulse hands it the program counter, status byte, stack pointer, an emulation-mode flag and the 16-bit address of the interrupt vector. The sequencer then runs the entry sequence on an 8-bit memory bus, with at most one transfer per cycle. The first cycle is a dummy read at the program counter and the second is a quiet internal cycle. Next come the return-state pushes to the stack and two vector reads from bank zero.

When the sequence ends, the block returns the new program counter, the updated status byte and the lowered stack pointer, and raises a one-cycle done pulse. The surrounding core takes over from there. In native mode the program bank is saved and the stack is a full 16-bit pointer. In emulation mode the bank push is dropped, the stack is confined to page one, and the saved status copy has its bit 4 cleared. The sequence is then one cycle shorter.

Top module: `irq_entry_seq`

## Requirements
- R1: In the cycle after an accepted start, the bus performs a read (bus_rd=1, bus_wr=0) at the 24-bit program counter that was presented with the start.
- R2: The cycle after the dummy read is internal: bus_rd and bus_wr are both 0.
- R3: In native mode (emul=0) four writes follow, in this order: program bank, PC bits 15:8, PC bits 7:0, status. They go to addresses {8'h00, SP}, {8'h00, SP-1}, {8'h00, SP-2} and {8'h00, SP-3}, with SP wrapping over 16 bits.
- R4: In emulation mode (emul=1) the bank write is skipped, leaving three writes (PC high, PC low, status). These go to {8'h00, 8'h01, L}, {8'h00, 8'h01, L-1} and {8'h00, 8'h01, L-2}, where L is SP bits 7:0 and wraps over 8 bits.
- R5: The pushed status equals the input status in native mode. In emulation mode it equals the input status with bit 4 forced to 0.
- R6: After the sequence, psr_out equals the input status with bit 2 (interrupt disable) set to 1 and bit 3 (decimal) cleared to 0. All other bits are unchanged.
- R7: Two reads follow the pushes: the low byte from {8'h00, VEC}, then the high byte from {8'h00, VEC+1}, with VEC+1 wrapping over 16 bits. The final pc_out is {8'h00, high, low}.
- R8: The final sp_out is SP-4 in native mode. In emulation mode it is {8'h01, L-3}.
- R9: done is high for exactly one cycle, namely the cycle after the vector high byte read. busy is high from the dummy read through the done cycle.
- R10: A start pulse that arrives while busy is high is ignored. The running sequence is unchanged, and no new sequence begins after done.
- R11: A synchronous reset returns the block to idle within one cycle: busy, done, bus_rd and bus_wr are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an interrupt entry (accepted only when idle) |
| emul | input | 1 | Emulation-mode flag sampled with start |
| pc_in | input | 24 | Program counter: bank in 23:16, offset in 15:0 |
| psr_in | input | 8 | Status byte |
| sp_in | input | 16 | Stack pointer |
| vec_addr | input | 16 | Bank-zero address of the vector low byte |
| bus_rdata | input | 8 | Read data, sampled at the end of a read cycle |
| bus_addr | output | 24 | Bus address of the current transfer |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| pc_out | output | 24 | Program counter after entry |
| psr_out | output | 8 | Status after entry |
| sp_out | output | 16 | Stack pointer after entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 16-bit offset, which give the 24-bit address. At that size it can sweep both modes against a set of stack values. The set includes SP low bytes of 00 and 01, so the page-one wrap and the 16-bit wrap both occur within a single sequence. Status bytes cover bit 4 set and clear, and one vector sits at FFFF so that its high-byte address wraps. Every case also pulses start twice while the block is busy, and one run is cut short by reset.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // Status bit positions the neighbouring core decodes
    localparam int IRQ_DIS_BIT = 2;
    localparam int DEC_BIT     = 3;
    localparam int BRK_BIT     = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_INTERNAL,
        ST_PUSH_BANK,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_PSR,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/irq_stack_step.sv
// Stack address for the current push and the pointer value after it.
module irq_stack_step #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 16
) (
    input  logic              emul,
    input  logic [OFF_W-1:0]  sp,
    output logic [OFF_W-1:0]  push_addr,
    output logic [OFF_W-1:0]  sp_next
);
    localparam int HI_W = OFF_W - DATA_W;
    localparam logic [HI_W-1:0]   PAGE_ONE = HI_W'(1);
    localparam logic [DATA_W-1:0] ONE_LO   = DATA_W'(1);
    localparam logic [OFF_W-1:0]  ONE_FULL = OFF_W'(1);

    always_comb begin
        if (emul) begin
            push_addr = {PAGE_ONE, sp[DATA_W-1:0]};
            sp_next   = {PAGE_ONE, sp[DATA_W-1:0] - ONE_LO};
        end else begin
            push_addr = sp;
            sp_next   = sp - ONE_FULL;
        end
    end
endmodule

// File: rtl/irq_status_fmt.sv
// Status copy written to the stack, and status held after entry.
module irq_status_fmt
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              emul,
    input  logic [DATA_W-1:0] psr,
    output logic [DATA_W-1:0] psr_push,
    output logic [DATA_W-1:0] psr_after
);
    always_comb begin
        psr_push = psr;
        if (emul) begin
            psr_push[BRK_BIT] = 1'b0;
        end
        psr_after              = psr;
        psr_after[IRQ_DIS_BIT] = 1'b1;
        psr_after[DEC_BIT]     = 1'b0;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      emul,
    input  logic [DATA_W+OFF_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]         psr_in,
    input  logic [OFF_W-1:0]          sp_in,
    input  logic [OFF_W-1:0]          vec_addr,
    input  logic [DATA_W-1:0]         bus_rdata,
    output logic [DATA_W+OFF_W-1:0]   bus_addr,
    output logic                      bus_rd,
    output logic                      bus_wr,
    output logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W+OFF_W-1:0]   pc_out,
    output logic [DATA_W-1:0]         psr_out,
    output logic [OFF_W-1:0]          sp_out,
    output logic                      busy,
    output logic                      done
);
    localparam int BANK_W = DATA_W;
    localparam int ADDR_W = BANK_W + OFF_W;
    localparam int HI_W   = OFF_W - DATA_W;
    localparam logic [BANK_W-1:0] BANK_ZERO = '0;
    localparam logic [HI_W-1:0]   PAGE_ONE  = HI_W'(1);
    localparam logic [OFF_W-1:0]  OFF_ONE   = OFF_W'(1);

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   psr;
        logic [OFF_W-1:0]    sp;
        logic                emul;
        logic [OFF_W-1:0]    vec;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic [OFF_W-1:0]  push_addr, sp_next;
    logic [DATA_W-1:0] psr_push, psr_after;

    irq_stack_step #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_stack (
        .emul      (cur_q.emul),
        .sp        (cur_q.sp),
        .push_addr (push_addr),
        .sp_next   (sp_next)
    );

    irq_status_fmt #(.DATA_W(DATA_W)) u_status (
        .emul      (cur_q.emul),
        .psr       (cur_q.psr),
        .psr_push  (psr_push),
        .psr_after (psr_after)
    );

    always_comb begin
        nxt_d     = cur_q;
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        done      = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.state = ST_DUMMY;
                    nxt_d.pc    = pc_in;
                    nxt_d.psr   = psr_in;
                    nxt_d.emul  = emul;
                    nxt_d.vec   = vec_addr;
                    nxt_d.sp    = emul ? {PAGE_ONE, sp_in[DATA_W-1:0]} : sp_in;
                end
            end
            ST_DUMMY: begin
                bus_rd      = 1'b1;
                bus_addr    = cur_q.pc;
                nxt_d.state = ST_INTERNAL;
            end
            ST_INTERNAL: begin
                nxt_d.state = cur_q.emul ? ST_PUSH_HI : ST_PUSH_BANK;
            end
            ST_PUSH_BANK: begin
                bus_wr      = 1'b1;
                bus_addr    = {BANK_ZERO, push_addr};
                bus_wdata   = cur_q.pc[ADDR_W-1:OFF_W];
                nxt_d.sp    = sp_next;
                nxt_d.state = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                bus_wr      = 1'b1;
                bus_addr    = {BANK_ZERO, push_addr};
                bus_wdata   = cur_q.pc[OFF_W-1:DATA_W];
                nxt_d.sp    = sp_next;
                nxt_d.state = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                bus_wr      = 1'b1;
                bus_addr    = {BANK_ZERO, push_addr};
                bus_wdata   = cur_q.pc[DATA_W-1:0];
                nxt_d.sp    = sp_next;
                nxt_d.state = ST_PUSH_PSR;
            end
            ST_PUSH_PSR: begin
                bus_wr      = 1'b1;
                bus_addr    = {BANK_ZERO, push_addr};
                bus_wdata   = psr_push;
                nxt_d.sp    = sp_next;
                nxt_d.psr   = psr_after;
                nxt_d.state = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                bus_rd                 = 1'b1;
                bus_addr               = {BANK_ZERO, cur_q.vec};
                nxt_d.pc[DATA_W-1:0]   = bus_rdata;
                nxt_d.state            = ST_VEC_HI;
            end
            ST_VEC_HI: begin
                bus_rd                      = 1'b1;
                bus_addr                    = {BANK_ZERO, cur_q.vec + OFF_ONE};
                nxt_d.pc[OFF_W-1:DATA_W]    = bus_rdata;
                nxt_d.pc[ADDR_W-1:OFF_W]    = BANK_ZERO;
                nxt_d.state                 = ST_FINISH;
            end
            ST_FINISH: begin
                done        = 1'b1;
                nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{state: ST_IDLE, pc: '0, psr: '0, sp: '0, emul: 1'b0, vec: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy    = (cur_q.state != ST_IDLE);
    assign pc_out  = cur_q.pc;
    assign psr_out = cur_q.psr;
    assign sp_out  = cur_q.sp;

    AST_DUMMY_AT_PC: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (bus_rd && !bus_wr && bus_addr == $past(pc_in))); // R1
    AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_DUMMY) |=> (!bus_rd && !bus_wr)); // R2
    AST_PUSH_IN_BANK0: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (bus_addr[ADDR_W-1:OFF_W] == BANK_ZERO)); // R3
    AST_EMUL_PAGE_ONE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && cur_q.emul) |-> (bus_addr[OFF_W-1:DATA_W] == PAGE_ONE)); // R4
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R2
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_rd)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R10
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy && !bus_rd && !bus_wr && !done)); // R11

endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        emul = 1'b0;
    logic [23:0] pc_in = '0;
    logic [7:0]  psr_in = '0;
    logic [15:0] sp_in = '0;
    logic [15:0] vec_addr = '0;
    logic [7:0]  bus_rdata = '0;
    logic [23:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [23:0] pc_out;
    logic [7:0]  psr_out;
    logic [15:0] sp_out;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .start(start), .emul(emul), .pc_in(pc_in),
        .psr_in(psr_in), .sp_in(sp_in), .vec_addr(vec_addr), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .pc_out(pc_out), .psr_out(psr_out), .sp_out(sp_out), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic load_junk();
        emul     = ~emul;
        pc_in    = ~pc_in;
        psr_in   = ~psr_in;
        sp_in    = ~sp_in;
        vec_addr = ~vec_addr;
    endtask

    task automatic run_case(input logic em, input logic [23:0] pc, input logic [7:0] psr,
                            input logic [15:0] sp, input logic [15:0] vec,
                            input logic [7:0] vlo, input logic [7:0] vhi);
        logic [7:0]  exp_data [4];
        logic [23:0] exp_addr [4];
        logic [7:0]  lo;
        logic [7:0]  pushed_psr;
        logic [15:0] exp_sp;
        int np;
        lo = sp[7:0];
        pushed_psr = em ? (psr & 8'hEF) : psr;
        if (em) begin
            np = 3;
            exp_data[0] = pc[15:8]; exp_data[1] = pc[7:0]; exp_data[2] = pushed_psr;
            exp_data[3] = 8'h00;
            for (int k = 0; k < 4; k++) exp_addr[k] = {8'h00, 8'h01, lo - 8'(k)};
            exp_sp = {8'h01, lo - 8'd3};
        end else begin
            np = 4;
            exp_data[0] = pc[23:16]; exp_data[1] = pc[15:8]; exp_data[2] = pc[7:0];
            exp_data[3] = pushed_psr;
            for (int k = 0; k < 4; k++) exp_addr[k] = {8'h00, sp - 16'(k)};
            exp_sp = sp - 16'd4;
        end

        @(negedge clk);
        start = 1'b1; emul = em; pc_in = pc; psr_in = psr; sp_in = sp; vec_addr = vec;
        @(negedge clk);
        start = 1'b0; load_junk();
        chk("R1 dummy strobe", {30'd0, bus_rd, bus_wr}, 32'd2);
        chk("R1 dummy addr", {8'd0, bus_addr}, {8'd0, pc});
        chk("R9 busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R2 internal quiet", {30'd0, bus_rd, bus_wr}, 32'd0);
        start = 1'b1;                      // R10: ignored while busy
        for (int k = 0; k < np; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(em ? "R4 push strobe" : "R3 push strobe", {30'd0, bus_rd, bus_wr}, 32'd1);
            chk(em ? "R4 push addr" : "R3 push addr", {8'd0, bus_addr}, {8'd0, exp_addr[k]});
            chk(k == np - 1 ? "R5 pushed status" : (em ? "R4 push data" : "R3 push data"),
                {24'd0, bus_wdata}, {24'd0, exp_data[k]});
        end
        @(negedge clk);
        chk("R7 vec lo read", {30'd0, bus_rd, bus_wr}, 32'd2);
        chk("R7 vec lo addr", {8'd0, bus_addr}, {16'd0, vec});
        bus_rdata = vlo;
        @(negedge clk);
        chk("R7 vec hi read", {30'd0, bus_rd, bus_wr}, 32'd2);
        chk("R7 vec hi addr", {8'd0, bus_addr}, {16'd0, vec + 16'd1});
        bus_rdata = vhi;
        @(negedge clk);
        chk("R9 done high", {31'd0, done}, 32'd1);
        chk("R7 pc_out", {8'd0, pc_out}, {16'd0, vhi, vlo});
        chk("R6 psr_out", {24'd0, psr_out}, {24'd0, (psr | 8'h04) & 8'hF7});
        chk("R8 sp_out", {16'd0, sp_out}, {16'd0, exp_sp});
        start = 1'b1;                      // R10: ignored during done
        @(negedge clk);
        start = 1'b0;
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
        chk("R10 no restart", {31'd0, busy}, 32'd0);
        chk("R10 no strobe", {30'd0, bus_rd, bus_wr}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] sps [4];
        logic [7:0]  psrs [4];
        logic [15:0] vecs [2];
        sps[0] = 16'h01FF; sps[1] = 16'h0000; sps[2] = 16'h1201; sps[3] = 16'h8003;
        psrs[0] = 8'h00; psrs[1] = 8'hFF; psrs[2] = 8'h10; psrs[3] = 8'h2C;
        vecs[0] = 16'hFFEE; vecs[1] = 16'hFFFF;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset done", {31'd0, done}, 32'd0);
        chk("R11 reset strobes", {30'd0, bus_rd, bus_wr}, 32'd0);

        // Reset in the middle of a sequence
        start = 1'b1; emul = 1'b0; pc_in = 24'h123456; psr_in = 8'h00;
        sp_in = 16'h01FF; vec_addr = 16'hFFEA;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 mid-run busy", {31'd0, busy}, 32'd0);
        chk("R11 mid-run strobes", {30'd0, bus_rd, bus_wr}, 32'd0);
        chk("R11 mid-run done", {31'd0, done}, 32'd0);

        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int p = 0; p < 4; p++)
                    for (int v = 0; v < 2; v++)
                        run_case(m[0], {8'h80 + 8'(s * 4 + p), 8'h40 + 8'(v), 8'h11 * 8'(p + 1)},
                                 psrs[p], sps[s], vecs[v],
                                 8'h5A ^ 8'(m * 16 + s * 4 + p), 8'hC3 + 8'(v * 8 + s));
        finish_run();
    end
endmodule